// File: doc/BRIEF.md
# Iterative Vector Magnitude Unit

The unit returns the Euclidean length of a short vector of signed integers, rounded down to an integer. A single start pulse captures every element from a wide parallel input. The unit then takes the absolute value of each element, squares it, and adds it to a wide running sum, one element per clock. After that it finds the integer square root of the sum with a digit-pair method that produces one result bit per step.

A caller raises `start` for one cycle while the unit is idle. `busy` stays high for the whole computation. At the end, `done` pulses for one cycle and `result` holds `floor(sqrt(sum of squares))`. `result` keeps that value until the next start is accepted.

The running sum is twice the element width plus eight bits of headroom, so sums of up to 256 full-scale squares cannot overflow. The result is half the width of the sum. The number of cycles varies with the data. The alignment phase skips leading zero bit-pairs of the sum, so small inputs finish sooner.

Top module: `vec_magnitude`

## Requirements
- R1: `busy` is high in the first cycle after a start pulse is accepted, and it stays high in every cycle until the cycle in which `done` is high.
- R2: While `busy` is high, a pulse on `start` is ignored. The result of the running operation comes only from the vector captured at its own start.
- R3: `result` equals floor(sqrt(x0^2 + x1^2 + x2^2 + x3^2)), where element k occupies bits [32k+31:32k] of `vec_in` as a two's-complement number.
- R4: A negative element contributes the same square as its magnitude. This includes the most negative value, -2^31, which contributes 2^62.
- R5: A vector of all zeros gives a result of zero.
- R6: `done` is high for exactly one cycle per operation, and `busy` is low in that cycle.
- R7: After `done`, `result` holds its value until the next accepted start.
- R8: Full-scale vectors give the exact answer. Four elements of -2^31 give 2^32. Four elements of 2^31-1 give 2^32-2.
- R9: Each operation starts from a cleared sum and a cleared result, so its answer does not depend on any earlier operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin; acted on only while idle |
| vec_in | input | 128 | Four signed 32-bit elements, element k at bits [32k+31:32k] |
| busy | output | 1 | High while an operation is in progress |
| done | output | 1 | One-cycle pulse when `result` becomes valid |
| result | output | 36 | Integer square root of the sum of squares |

## Verification
The assertions assume that `start` is a clean, synchronous signal. They also assume that reset is held long enough to clear the state before the first request. They say nothing about the timing of `start` pulses that arrive while the unit is busy. The stimulus raises `start` only away from the active clock edge. It sends new requests both while the unit is idle and, on purpose, in the middle of a computation. The element values come from a fixed-seed random source. They mix full-range words, small values of either sign, and values near the two extremes. Directed vectors cover zero and full scale.

// File: rtl/vec_magnitude.sv
module vec_magnitude #(
  parameter int ELEMS = 4,
  parameter int EW    = 32,
  parameter int HEAD  = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [ELEMS*EW-1:0]           vec_in,
  output logic                          busy,
  output logic                          done,
  output logic [(2*EW+HEAD)/2-1:0]      result
);
  localparam int AW = 2*EW + HEAD;
  localparam int RW = AW/2;
  localparam int SW = 2*EW;
  localparam int IW = (ELEMS > 1) ? $clog2(ELEMS) : 1;

  typedef enum logic [1:0] {S_IDLE, S_ACC, S_ALIGN, S_ROOT} state_t;

  state_t              st;
  logic [ELEMS*EW-1:0] vec_q;
  logic [IW-1:0]       idx;
  logic [AW-1:0]       rem_q, res_q, bit_q;
  logic                done_q;

  logic [EW-1:0] elem, mag;
  logic [SW-1:0] sq;
  logic [AW-1:0] trial_sum;

  assign elem      = vec_q[idx*EW +: EW];
  assign mag       = elem[EW-1] ? (~elem + 1'b1) : elem;
  assign sq        = SW'(mag) * SW'(mag);
  assign trial_sum = res_q + bit_q;

  assign busy   = (st != S_IDLE);
  assign done   = done_q;
  assign result = res_q[RW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      vec_q  <= '0;
      idx    <= '0;
      rem_q  <= '0;
      res_q  <= '0;
      bit_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            vec_q <= vec_in;
            idx   <= '0;
            rem_q <= '0;
            res_q <= '0;
            bit_q <= AW'(1) << (AW-2);
            st    <= S_ACC;
          end
        end
        S_ACC: begin
          rem_q <= rem_q + AW'(sq);
          idx   <= idx + 1'b1;
          if (idx == IW'(ELEMS-1)) st <= S_ALIGN;
        end
        S_ALIGN: begin
          if (bit_q > rem_q) bit_q <= bit_q >> 2;
          else               st    <= S_ROOT;
        end
        S_ROOT: begin
          if (bit_q == '0) begin
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else begin
            if (rem_q >= trial_sum) begin
              rem_q <= rem_q - trial_sum;
              res_q <= (res_q >> 1) + bit_q;
            end else begin
              res_q <= res_q >> 1;
            end
            bit_q <= bit_q >> 2;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vec_magnitude_chk.sv
module vec_magnitude_chk #(
  parameter int RW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [RW-1:0] result
);
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R1

  AST_BUSY_ENDS_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R1

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R6

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(result)); // R7
endmodule

bind vec_magnitude vec_magnitude_chk #(.RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start),
  .busy(busy), .done(done), .result(result)
);

// File: tb/vec_magnitude_tb_top.sv
module vec_magnitude_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [127:0] vec_in = '0;
  logic         busy, done;
  logic [35:0]  result;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_magnitude dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .vec_in(vec_in),
    .busy(busy), .done(done), .result(result)
  );

  function automatic logic [71:0] sum_sq(input logic [127:0] v);
    logic [71:0] s = '0;
    for (int i = 0; i < N; i++) begin
      logic [31:0] e = v[i*32 +: 32];
      logic [31:0] a = e[31] ? (~e + 32'd1) : e;
      s = s + 72'(a) * 72'(a);
    end
    return s;
  endfunction

  function automatic logic [35:0] ref_mag(input logic [127:0] v);
    logic [71:0] s = sum_sq(v);
    logic [35:0] r = '0;
    for (int b = 35; b >= 0; b--) begin
      logic [35:0] c = r | (36'd1 << b);
      if (72'(c) * 72'(c) <= s) r = c;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [127:0] v, input string req,
                        input bit interfere, input logic [127:0] other);
    logic [35:0] exp = ref_mag(v);
    int cyc = 0;
    bit saw_low = 1'b0;
    @(negedge clk);
    vec_in = v; start = 1'b1;
    @(negedge clk);
    start = 1'b0; vec_in = other;
    check("R1 busy after start", busy, 1);
    while (!done && cyc < 1000) begin
      if (interfere && cyc == 2) start = 1'b1;
      if (interfere && cyc == 3) start = 1'b0;
      if (!busy) saw_low = 1'b1;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    if (cyc >= 1000) begin
      check("R1 operation timed out", 0, 1);
      return;
    end
    check("R1 busy held until done", saw_low, 0);
    check("R6 busy low with done", busy, 0);
    check(req, result, exp);
    @(negedge clk);
    check("R6 done single cycle", done, 0);
    repeat (3) @(negedge clk);
    check("R7 result held", result, exp);
  endtask

  function automatic logic [31:0] rand_elem();
    case ($urandom % 4)
      0: return $urandom;
      1: return 32'($signed($urandom % 201) - 100);
      2: return 32'h8000_0000 + ($urandom % 4);
      default: return 32'h7FFF_FFFF - ($urandom % 4);
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [127:0] v;
    int unused;
    unused = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    check("reset busy", busy, 0);
    check("reset done", done, 0);
    check("reset result", result, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_op('0, "R5 zero vector", 0, '0);
    run_op({4{32'h8000_0000}}, "R8 most negative full scale", 0, '0);
    check("R8 value is 2^32", result, 64'h1_0000_0000);
    run_op({4{32'h7FFF_FFFF}}, "R8 most positive full scale", 0, '0);
    check("R8 value is 2^32-2", result, 64'hFFFF_FFFE);
    run_op({32'd0, 32'd0, 32'd4, 32'd3}, "R3 3-4-5", 0, '0);
    check("R3 equals five", result, 5);
    run_op({32'd0, 32'd0, -32'sd4, -32'sd3}, "R4 negative 3-4-5", 0, '0);
    check("R4 equals five", result, 5);
    run_op({32'hFFFF_FFFF, 32'd1, 32'hFFFF_FFFF, 32'd1}, "R4 mixed signs", 0, '0);
    run_op({4{32'h8000_0000}}, "R9 large before zero", 0, '0);
    run_op('0, "R9 zero after large", 0, '0);
    run_op({32'd0, 32'd0, 32'd0, 32'd2}, "R2 start while busy ignored", 1, {4{32'h7FFF_FFFF}});
    check("R2 result from captured vector", result, 2);

    for (int n = 0; n < 60; n++) begin
      for (int k = 0; k < N; k++) v[k*32 +: 32] = rand_elem();
      run_op(v, "R3 random vector", (n % 5) == 0, {$urandom, $urandom, $urandom, $urandom});
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule